// File: doc/BRIEF.md
# Fractional Multiplier with Fused Post-Shift

This unit is the multiply datapath of a 16-bit fixed-point signal processor. It takes two signed two's-complement operands and a mode select. In integer mode it returns the low half of the product. In fractional mode, where both operands are in 1.15 format, it returns a 16-bit window of the product. That window is moved left by a 3-bit shift amount in the same operation.

The shift is taken from the full 32-bit product rather than from an already truncated 16-bit result, so bits below the usual 1.15 window move up into the vacated positions instead of zeros. A compiler can use this to undo the growth in integer word length that multiplication causes without throwing precision away. When the shifted value no longer fits in 16 bits, the fractional result clamps to the most positive or most negative code and a flag is raised.

The unit has a single register stage: a result and its flag appear one clock after the input strobe and hold until the next strobe.

Top module: `fmul_shift_unit`

## Requirements
- R1: In integer mode (`frac_mode` = 0) the result is bits [15:0] of the signed 32-bit product of `op_a` and `op_b`, without saturation.
- R2: In integer mode `shift_amt` has no effect on `result` or `ovf`.
- R3: In integer mode `ovf` is 1 exactly when the signed product lies outside -32768..32767, and `result` still wraps.
- R4: In fractional mode (`frac_mode` = 1), with n = `shift_amt` (0 to 7), the result is product bits [30-n:15-n], which is the product shifted left by n and then arithmetically right by 15, truncated toward minus infinity. Low product bits fill the positions the shift vacates.
- R5: In fractional mode, when product bits [31:30-n] are not all equal, `ovf` is 1 and `result` is 16'h7FFF for a positive product or 16'h8000 for a negative one. Otherwise `ovf` is 0.
- R6: In fractional mode with n = 0, 16'h8000 times 16'h8000 gives `result` 16'h7FFF and `ovf` 1.
- R7: `out_valid` is 1 in the cycle after a cycle with `in_valid` = 1 and is 0 otherwise. `result` and `ovf` update on the same edge.
- R8: In a cycle with `in_valid` = 0, `result` and `ovf` keep their previous values.
- R9: While `rst` is 1 at a clock edge, `out_valid`, `result` and `ovf` become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_a | input | 16 | First signed operand |
| op_b | input | 16 | Second signed operand |
| frac_mode | input | 1 | 0 = integer multiply, 1 = fractional multiply |
| shift_amt | input | 3 | Left shift applied to the fractional product |
| out_valid | output | 1 | Result registered from the previous cycle's strobe |
| result | output | 16 | Registered 16-bit result |
| ovf | output | 1 | Registered overflow flag |

## Verification
Alignment shifting and saturation can happen in the same operation. An operand pair that fits at a small shift can overflow at a larger one, for example 0.5 times 0.5 at shifts 0, 1 and 2, and for -1 times 0.5 at shifts 1 and 2. The bench drives these pairs back to back through every shift amount and judges each clamped or unclamped value against a behavioural model that uses 64-bit integers. Random traffic with mixed modes and gaps in the strobe then checks the hold behaviour and the output register in every cycle.

// File: rtl/fmul_pkg.sv
package fmul_pkg;
  localparam int unsigned DATA_W_DEF  = 16;
  localparam int unsigned SHIFT_W_DEF = 3;

  typedef enum logic {
    MUL_INT  = 1'b0,
    MUL_FRAC = 1'b1
  } mul_mode_e;
endpackage

// File: rtl/fmul_product.sv
module fmul_product #(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0]   mul_a,
  input  logic [DATA_W-1:0]   mul_b,
  output logic [2*DATA_W-1:0] mul_p
);
  localparam int unsigned PROD_W = 2 * DATA_W;

  logic signed [PROD_W-1:0] a_ext;
  logic signed [PROD_W-1:0] b_ext;

  always_comb begin
    a_ext = PROD_W'($signed(mul_a));
    b_ext = PROD_W'($signed(mul_b));
    mul_p = a_ext * b_ext;
  end
endmodule

// File: rtl/fmul_int_select.sv
module fmul_int_select #(
  parameter int unsigned DATA_W = 16
) (
  input  logic [2*DATA_W-1:0] prod,
  output logic [DATA_W-1:0]   int_res,
  output logic                int_ovf
);
  localparam int unsigned PROD_W = 2 * DATA_W;
  localparam int unsigned HI_W   = PROD_W - DATA_W + 1;

  logic [HI_W-1:0] hi_bits;

  always_comb begin
    hi_bits = prod[PROD_W-1:DATA_W-1];
    int_res = prod[DATA_W-1:0];
    int_ovf = !((hi_bits == '0) || (hi_bits == '1));
  end
endmodule

// File: rtl/fmul_frac_align.sv
module fmul_frac_align #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned SHIFT_W = 3
) (
  input  logic [2*DATA_W-1:0] prod,
  input  logic [SHIFT_W-1:0]  shamt,
  output logic [DATA_W-1:0]   frac_res,
  output logic                frac_ovf
);
  localparam int unsigned PROD_W = 2 * DATA_W;
  localparam int unsigned N_SH   = 1 << SHIFT_W;
  localparam logic [DATA_W-1:0] POS_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NEG_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] win   [N_SH];
  logic [N_SH-1:0]   fits;

  for (genvar g = 0; g < N_SH; g++) begin : g_win
    logic [g+1:0] top_bits;
    always_comb begin
      top_bits = prod[PROD_W-1 -: (g+2)];
      win[g]   = prod[PROD_W-2-g -: DATA_W];
      fits[g]  = (top_bits == '0) || (top_bits == '1);
    end
  end

  always_comb begin
    frac_ovf = !fits[shamt];
    if (frac_ovf) frac_res = prod[PROD_W-1] ? NEG_MIN : POS_MAX;
    else          frac_res = win[shamt];
  end
endmodule

// File: rtl/fmul_shift_unit.sv
module fmul_shift_unit
  import fmul_pkg::*;
#(
  parameter int unsigned DATA_W  = DATA_W_DEF,
  parameter int unsigned SHIFT_W = SHIFT_W_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [DATA_W-1:0]  op_a,
  input  logic [DATA_W-1:0]  op_b,
  input  logic               frac_mode,
  input  logic [SHIFT_W-1:0] shift_amt,
  output logic               out_valid,
  output logic [DATA_W-1:0]  result,
  output logic               ovf
);
  localparam int unsigned PROD_W = 2 * DATA_W;
  localparam logic [DATA_W-1:0] POS_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NEG_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  logic [PROD_W-1:0] prod_w;
  logic [DATA_W-1:0] int_res, frac_res, nxt_res;
  logic              int_ovf, frac_ovf, nxt_ovf;
  mul_mode_e         mode_sel;
  mul_mode_e         r_mode;

  fmul_product #(.DATA_W(DATA_W)) u_prod (
    .mul_a (op_a),
    .mul_b (op_b),
    .mul_p (prod_w)
  );

  fmul_int_select #(.DATA_W(DATA_W)) u_int (
    .prod    (prod_w),
    .int_res (int_res),
    .int_ovf (int_ovf)
  );

  fmul_frac_align #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) u_frac (
    .prod     (prod_w),
    .shamt    (shift_amt),
    .frac_res (frac_res),
    .frac_ovf (frac_ovf)
  );

  always_comb begin
    mode_sel = mul_mode_e'(frac_mode);
    if (mode_sel == MUL_FRAC) begin
      nxt_res = frac_res;
      nxt_ovf = frac_ovf;
    end else begin
      nxt_res = int_res;
      nxt_ovf = int_ovf;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      ovf       <= 1'b0;
      r_mode    <= MUL_INT;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= nxt_res;
        ovf    <= nxt_ovf;
        r_mode <= mode_sel;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);  // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);  // R7
  AST_HOLD_OUTPUT: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(ovf)));  // R8
  AST_INT_LOW_HALF: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !frac_mode) |=> (result == $past(prod_w[DATA_W-1:0])));  // R1
  AST_SAT_CODE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (r_mode == MUL_FRAC) && ovf) |-> ((result == POS_MAX) || (result == NEG_MIN)));  // R5
  AST_FRAC_SIGN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && frac_mode && !frac_ovf) |-> (frac_res[DATA_W-1] == prod_w[PROD_W-1]));  // R4
endmodule

// File: tb/fmul_shift_unit_tb.sv
`timescale 1ns/1ps
module fmul_shift_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [15:0] op_a, op_b;
  logic        frac_mode;
  logic [2:0]  shift_amt;
  logic        out_valid;
  logic [15:0] result;
  logic        ovf;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic        m_vld;
  logic [15:0] m_res;
  logic        m_ovf;

  always #2.5 clk = ~clk;

  fmul_shift_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .frac_mode(frac_mode), .shift_amt(shift_amt),
    .out_valid(out_valid), .result(result), .ovf(ovf)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [15:0] a, input logic [15:0] b,
                                input logic fm, input logic [2:0] n,
                                output logic [15:0] r, output logic o);
    longint p, q;
    p = longint'($signed(a)) * longint'($signed(b));
    if (!fm) begin
      r = p[15:0];
      o = (p > 32767) || (p < -32768);
    end else begin
      q = (p <<< n) >>> 15;
      if (q > 32767)       begin r = 16'h7FFF; o = 1'b1; end
      else if (q < -32768) begin r = 16'h8000; o = 1'b1; end
      else                 begin r = q[15:0];  o = 1'b0; end
    end
  endfunction

  task automatic cycle(input logic v, input logic [15:0] a, input logic [15:0] b,
                       input logic fm, input logic [2:0] n, input string tag);
    logic [15:0] r;
    logic        o;
    in_valid = v; op_a = a; op_b = b; frac_mode = fm; shift_amt = n;
    model(a, b, fm, n, r, o);
    m_vld = v;
    if (v) begin m_res = r; m_ovf = o; end
    @(posedge clk);
    @(negedge clk);
    chk("R7 out_valid", {31'd0, out_valid}, {31'd0, m_vld});
    chk(v ? tag : "R8", {16'd0, result}, {16'd0, m_res});
    chk(v ? tag : "R8", {31'd0, ovf}, {31'd0, m_ovf});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; op_a = 16'h1234; op_b = 16'h5678;
    frac_mode = 1'b0; shift_amt = 3'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R9 result", {16'd0, result}, 32'd0);
    chk("R9 ovf", {31'd0, ovf}, 32'd0);
    rst = 1'b0;
    m_vld = 1'b0; m_res = 16'h0; m_ovf = 1'b0;

    cycle(1, 16'd3, 16'd4, 0, 3'd0, "R1 int small");
    cycle(1, 16'd3, 16'd4, 0, 3'd5, "R2 int shift ignored");
    cycle(1, -16'sd7, 16'd9, 0, 3'd7, "R2 int negative");
    cycle(1, 16'd300, 16'd300, 0, 3'd0, "R3 int wrap with flag");
    cycle(1, 16'h8000, 16'd1, 0, 3'd0, "R3 int edge fits");
    cycle(0, 16'hFFFF, 16'hFFFF, 1, 3'd3, "R8");
    cycle(1, 16'h4000, 16'h4000, 1, 3'd0, "R4 half squared n0");
    cycle(1, 16'h4000, 16'h4000, 1, 3'd1, "R4 half squared n1");
    cycle(1, 16'h4000, 16'h4000, 1, 3'd2, "R5 shift overflow positive");
    cycle(1, 16'h0101, 16'h0101, 1, 3'd0, "R4 low bits n0");
    cycle(1, 16'h0101, 16'h0101, 1, 3'd7, "R4 low bits fill n7");
    cycle(1, 16'hFFFF, 16'h0001, 1, 3'd0, "R4 truncation negative");
    cycle(1, 16'h8000, 16'h8000, 1, 3'd0, "R6 minus one squared");
    cycle(1, 16'h8000, 16'h4000, 1, 3'd1, "R5 negative edge fits");
    cycle(1, 16'h8000, 16'h4000, 1, 3'd2, "R5 shift overflow negative");
    cycle(0, 16'd0, 16'd0, 0, 3'd0, "R8");
    cycle(0, 16'd5, 16'd5, 0, 3'd0, "R8");

    for (int i = 0; i < 400; i++) begin
      logic       v;
      logic       fm;
      v  = ($urandom % 4) != 0;
      fm = $urandom % 2;
      cycle(v, 16'($urandom), 16'($urandom), fm, 3'($urandom),
            fm ? "R4 random frac" : "R1 random int");
    end

    rst = 1'b1;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R9 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R9 result", {16'd0, result}, 32'd0);
    chk("R9 ovf", {31'd0, ovf}, 32'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule